// File: doc/BRIEF.md
# Multi-Lane Sync-Header Deskew

This block takes 66-bit blocks that have already been aligned on several lanes. Every lane has its own block-valid strobe and its own lock flag, and all lanes arrive in one shared word-clock domain. Once every lane reports lock, the block times the arrival of the first block on each lane. The count is in clock cycles, measured from the earliest lane. The block then delays each lane by the difference between the latest lane's arrival and its own. As a result, blocks that left the far end together reach the output on the same cycle.

The block has no marker blocks to work with. It relies only on the header timing, so the skew it can repair is bounded by `MAX_SKEW` (32 units by default, which is about half a block). If the measured spread is larger, the block raises an error and keeps the link down. If any lane drops lock, the link goes down and the block measures again from scratch. Each lane holds `MAX_SKEW+1` entries of storage in a tapped shift register.

Top module: `sync_deskew`

## Requirements
- R1: After reset, `link_up`, `deskew_err` and every bit of `out_vld` are 0.
- R2: Skew measurement begins only in the cycle after all `lane_lock` bits are 1. Valid strobes seen while any lock bit is 0 do not count toward the measurement.
- R3: Let M be the arrival index of the latest lane's first block, counted in cycles from the earliest lane's first block, where the earliest lane is index 0. If M <= `MAX_SKEW`, `link_up` is 1 from the edge that samples that latest block.
- R4: In normal operation all bits of `out_vld` are equal. A block sampled on lane i at edge t leaves at edge t + (M - s_i) + 1, where s_i is lane i's first-arrival index.
- R5: Each output lane carries exactly the 66-bit block that entered on the same lane. Lane i occupies bits [i*66 +: 66] of both `in_blk` and `out_blk`.
- R6: A spread of exactly `MAX_SKEW` is accepted, and the link comes up.
- R7: If no lane is still missing by count `MAX_SKEW`, nothing further happens. Otherwise, if a lane is still missing when the count reaches `MAX_SKEW+1`, `deskew_err` rises at that edge. `link_up` then stays 0 and no output block is produced.
- R8: If any lock bit is 0 at an edge, `link_up` and `deskew_err` are 0 after that edge, `out_vld` is 0 one edge later, and a new measurement starts once all lanes lock again.
- R9: An `out_vld` bit is 1 only if `link_up` was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_lock | input | LANES | Per-lane block-lock flag |
| in_vld | input | LANES | Per-lane block-valid strobe |
| in_blk | input | LANES*BLK_W | Per-lane incoming block, lane i at [i*BLK_W +: BLK_W] |
| link_up | output | 1 | All lanes locked, skew measured and within limit |
| deskew_err | output | 1 | Measured spread exceeded MAX_SKEW |
| out_vld | output | LANES | Per-lane aligned valid, all bits equal |
| out_blk | output | LANES*BLK_W | Aligned blocks, same lane order as the input |

## Verification
`link_up` changes at the edge that samples the latest lane's first block. `deskew_err` changes at the edge where the count from the first arrival passes `MAX_SKEW`. An output group is due one edge after the latest lane's copy of that block was sampled. The bench drives inputs on falling edges and samples outputs on the next falling edge, so every sample reflects exactly one rising edge. It numbers these samples from the first driven cycle and derives each expected value from the skew vector and the block period. Lock-drop effects are checked on the first and second samples after the lock bit is cleared.

// File: rtl/sync_deskew_pkg.sv
package sync_deskew_pkg;

   typedef enum logic [1:0] {
      SD_WAIT = 2'd0,
      SD_MEAS = 2'd1,
      SD_RUN  = 2'd2,
      SD_FAIL = 2'd3
   } sd_state_e;

   function automatic int sd_cnt_width(input int max_skew);
      return $clog2(max_skew + 2);
   endfunction

endpackage

// File: rtl/sdsk_delay_line.sv
module sdsk_delay_line #(
   parameter int W     = 67,
   parameter int DEPTH = 33,
   parameter int SW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] sel,
   output logic [W-1:0]  tap
);

   logic [W-1:0] stage [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
      end else begin
         stage[0] <= din;
         for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
      end
   end

   // tap index d returns the word captured d+1 edges ago
   always_comb begin
      tap = '0;
      for (int k = 0; k < DEPTH; k++)
         if (int'(sel) == k) tap = stage[k];
   end

endmodule

// File: rtl/sdsk_skew_meas.sv
module sdsk_skew_meas
   import sync_deskew_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int MAX_SKEW = 32,
   parameter int CW       = sd_cnt_width(MAX_SKEW)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES-1:0]           lane_lock,
   input  logic [LANES-1:0]           in_vld,
   output logic [LANES-1:0][CW-1:0]   lane_delay,
   output logic                       link_up,
   output logic                       deskew_err
);

   localparam logic [CW-1:0] LIMIT = CW'(MAX_SKEW);

   sd_state_e                  state;
   logic [LANES-1:0]           seen;
   logic                       started;
   logic [CW-1:0]              cnt;
   logic [LANES-1:0][CW-1:0]   arrive;
   logic [CW-1:0]              latest;
   logic [CW-1:0]              now_idx;
   logic [LANES-1:0]           seen_nxt;
   logic                       all_lock;

   assign all_lock = &lane_lock;
   assign now_idx  = started ? cnt : '0;
   assign seen_nxt = seen | in_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SD_WAIT;
         seen    <= '0;
         started <= 1'b0;
         cnt     <= '0;
         arrive  <= '0;
         latest  <= '0;
      end else if (!all_lock) begin
         state   <= SD_WAIT;
         seen    <= '0;
         started <= 1'b0;
         cnt     <= '0;
      end else begin
         case (state)
            SD_WAIT: begin
               state   <= SD_MEAS;
               seen    <= '0;
               started <= 1'b0;
               cnt     <= '0;
            end
            SD_MEAS: begin
               if (started)      cnt <= cnt + 1'b1;
               else if (|in_vld) begin
                  started <= 1'b1;
                  cnt     <= CW'(1);
               end
               for (int i = 0; i < LANES; i++)
                  if (in_vld[i] && !seen[i]) arrive[i] <= now_idx;
               seen <= seen_nxt;
               if (started && (cnt > LIMIT)) begin
                  state <= SD_FAIL;
               end else if (&seen_nxt) begin
                  state  <= SD_RUN;
                  latest <= now_idx;
               end
            end
            default: state <= state;
         endcase
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) lane_delay[i] = latest - arrive[i];
   end

   assign link_up    = (state == SD_RUN);
   assign deskew_err = (state == SD_FAIL);

endmodule

// File: rtl/sync_deskew.sv
module sync_deskew
   import sync_deskew_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int BLK_W    = 66,
   parameter int MAX_SKEW = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_lock,
   input  logic [LANES-1:0]        in_vld,
   input  logic [LANES*BLK_W-1:0]  in_blk,
   output logic                    link_up,
   output logic                    deskew_err,
   output logic [LANES-1:0]        out_vld,
   output logic [LANES*BLK_W-1:0]  out_blk
);

   localparam int CW    = sd_cnt_width(MAX_SKEW);
   localparam int DEPTH = MAX_SKEW + 1;
   localparam int LW    = BLK_W + 1;

   generate
      if (LANES < 1)    begin : g_bad_lanes $error("LANES must be at least 1"); end
      if (BLK_W < 3)    begin : g_bad_width $error("BLK_W must be at least 3"); end
      if (MAX_SKEW < 1) begin : g_bad_skew  $error("MAX_SKEW must be at least 1"); end
   endgenerate

   logic [LANES-1:0][CW-1:0] lane_delay;
   logic [LANES-1:0][LW-1:0] tap_word;

   sdsk_skew_meas #(
      .LANES   (LANES),
      .MAX_SKEW(MAX_SKEW),
      .CW      (CW)
   ) u_meas (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_lock (lane_lock),
      .in_vld    (in_vld),
      .lane_delay(lane_delay),
      .link_up   (link_up),
      .deskew_err(deskew_err)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LW-1:0] lane_in;
         logic [LW-1:0] lane_tap;
         assign lane_in = {in_vld[g], in_blk[g*BLK_W +: BLK_W]};

         sdsk_delay_line #(
            .W    (LW),
            .DEPTH(DEPTH),
            .SW   (CW)
         ) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (lane_in),
            .sel  (lane_delay[g]),
            .tap  (lane_tap)
         );

         assign tap_word[g] = lane_tap;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_vld[g]                 <= 1'b0;
               out_blk[g*BLK_W +: BLK_W]  <= '0;
            end else begin
               out_vld[g]                 <= link_up & tap_word[g][BLK_W];
               out_blk[g*BLK_W +: BLK_W]  <= tap_word[g][BLK_W-1:0];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sync_deskew_chk.sv
module sync_deskew_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] lane_lock,
   input logic             link_up,
   input logic             deskew_err,
   input logic [LANES-1:0] out_vld
);

   // R4: lanes leave together
   a_r4_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld == '0) || (&out_vld));

   // R9: output only after link was up
   a_r9_vld_after_up: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_vld) |-> $past(link_up));

   // R7: error and link-up are exclusive
   a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      deskew_err |-> !link_up);

   // R8: a missing lock drops the link at the next edge
   a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !(&lane_lock) |=> (!link_up && !deskew_err));

   // R8: outputs silent one edge after link is down
   a_r8_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (out_vld == '0));

   // R2: link comes up only with all lanes locked
   a_r2_up_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(&lane_lock));

endmodule

bind sync_deskew sync_deskew_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane_lock (lane_lock),
   .link_up   (link_up),
   .deskew_err(deskew_err),
   .out_vld   (out_vld)
);

// File: tb/sync_deskew_tb.sv
`timescale 1ns/1ps
module sync_deskew_tb;

   localparam int LANES = 4;
   localparam int BW    = 66;
   localparam int MAXS  = 32;
   localparam int P     = 40;
   localparam int NBLK  = 3;
   localparam int NCASE = 6;

   localparam int SKW [NCASE][LANES] = '{
      '{0, 0, 0, 0},
      '{0, 1, 2, 3},
      '{5, 0, 9, 2},
      '{32, 0, 16, 4},
      '{0, 33, 0, 0},
      '{7, 7, 0, 7}
   };
   localparam bit UP [NCASE] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic [LANES-1:0]      lane_lock;
   logic [LANES-1:0]      in_vld;
   logic [LANES*BW-1:0]   in_blk;
   logic                  link_up;
   logic                  deskew_err;
   logic [LANES-1:0]      out_vld;
   logic [LANES*BW-1:0]   out_blk;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sync_deskew #(.LANES(LANES), .BLK_W(BW), .MAX_SKEW(MAXS)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_lock (lane_lock),
      .in_vld    (in_vld),
      .in_blk    (in_blk),
      .link_up   (link_up),
      .deskew_err(deskew_err),
      .out_vld   (out_vld),
      .out_blk   (out_blk)
   );

   function automatic logic [BW-1:0] mk_blk(input int lane, input int k);
      return {2'b10, 32'(lane * 1000 + k), 32'hC0DE0000 ^ 32'(k * 7 + lane)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                      input logic [BW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_case(input int idx);
      int m;
      int last_c;
      m = 0;
      for (int i = 0; i < LANES; i++) if (SKW[idx][i] > m) m = SKW[idx][i];
      last_c = m + 1 + P * NBLK + 2;
      // drop lock with a stray strobe: R8 on clearing, R2 on being ignored
      @(negedge clk);
      lane_lock = '0;
      in_vld    = 4'b0001;
      in_blk[0 +: BW] = {BW{1'b1}};
      @(posedge clk); @(negedge clk);
      chk(link_up == 1'b0, "R8 link_up after lock loss", BW'(link_up), '0);
      chk(deskew_err == 1'b0, "R8 err after lock loss", BW'(deskew_err), '0);
      in_vld = '0;
      @(posedge clk); @(negedge clk);
      chk(out_vld == '0, "R8 out_vld one edge later", BW'(out_vld), '0);
      lane_lock = '1;
      @(posedge clk); @(negedge clk);
      chk(link_up == 1'b0, "R2 no link right after lock", BW'(link_up), '0);
      for (int c = 0; c <= last_c; c++) begin
         bit ev;
         int g;
         for (int i = 0; i < LANES; i++) begin
            int r;
            r = c - SKW[idx][i];
            in_vld[i] = (r >= 0) && (r % P == 0) && (r / P < NBLK);
            in_blk[i*BW +: BW] = (r >= 0) ? mk_blk(i, r / P) : '0;
         end
         @(posedge clk); @(negedge clk);
         g  = c - m - 1;
         ev = UP[idx] && (g >= 0) && (g % P == 0) && (g / P < NBLK);
         chk(link_up == (UP[idx] && c >= m), "R3/R6 link_up timing",
             BW'(link_up), BW'(UP[idx] && c >= m));
         chk(deskew_err == (!UP[idx] && c >= MAXS + 1), "R7 deskew_err timing",
             BW'(deskew_err), BW'(!UP[idx] && c >= MAXS + 1));
         chk(out_vld == {LANES{ev}}, "R4/R9 out_vld alignment",
             BW'(out_vld), BW'({LANES{ev}}));
         if (ev)
            for (int i = 0; i < LANES; i++)
               chk(out_blk[i*BW +: BW] == mk_blk(i, g / P), "R5 block data",
                   out_blk[i*BW +: BW], mk_blk(i, g / P));
      end
      in_vld = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      lane_lock = '0;
      in_vld    = '0;
      in_blk    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      // R1 reset state
      chk(link_up == 1'b0,    "R1 link_up after reset", BW'(link_up), '0);
      chk(deskew_err == 1'b0, "R1 err after reset",     BW'(deskew_err), '0);
      chk(out_vld == '0,      "R1 out_vld after reset", BW'(out_vld), '0);

      for (int t = 0; t < NCASE; t++) run_case(t);

      // R8 directed: lock loss on one lane while running
      @(negedge clk);
      lane_lock = 4'b1011;
      in_vld    = '1;
      @(posedge clk); @(negedge clk);
      chk(link_up == 1'b0, "R8 single-lane lock loss", BW'(link_up), '0);
      @(posedge clk); @(negedge clk);
      chk(out_vld == '0, "R8 output stops", BW'(out_vld), '0);
      in_vld = '0;
      // R8 restart after error case
      run_case(4);
      run_case(1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule